// File: doc/BRIEF.md
# Privileged-mode interrupt gating controller

This block decides which interrupt and trap sources a CPU core may accept while it runs in a privileged management mode. It follows a mode-entry pulse and a resume pulse. It keeps the core's interrupt-enable and trap flags and a debug-enable flag. At each instruction boundary it grants at most one pending source: a non-maskable request, a maskable request or a software interrupt.

When the mode is entered, maskable interrupts, single-step and debug traps are switched off, and the non-maskable request is blocked. A non-maskable edge that arrives while the block is in force is held in a one-deep latch. The block is lifted by an IRET pulse or by resume. After resume, a held request wins the very first boundary, so it is taken before the interrupted code goes on. Software interrupts are never gated. Handler software may turn interrupts back on (STI), turn single-step back on, or arm debug traps while still inside the mode. On resume, the three flags go back to the values they had at entry.

The grant strobes are combinational. They are formed from the flag state held at the start of the cycle and from the request inputs of that cycle. Pulses on the control inputs act at the next clock edge.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset the block is outside the mode, the interrupt-enable, trap and debug-enable outputs are 0, and no non-maskable request is blocked or pending: an edge followed by a boundary is granted.
- R2: Entry (accepted only while outside the mode) clears the interrupt-enable flag on the next edge, and no maskable grant is given while that flag is 0.
- R3: Entry clears the trap flag and the debug-enable flag on the next edge.
- R4: Entry blocks the non-maskable request. While it is blocked, an arriving edge is latched and no non-maskable grant is given.
- R5: The latch holds at most one request. Several edges while blocked produce exactly one grant once the block is lifted.
- R6: An IRET pulse lifts the block, and a latched request is then granted at the next boundary.
- R7: Resume (accepted only while in the mode) lifts the block. A latched request wins the first boundary after resume, ahead of maskable and software requests.
- R8: A software request at a boundary is granted whenever no non-maskable or maskable grant is given in that cycle, whether inside or outside the mode.
- R9: The STI, trap-set and debug-arm pulses set their flag at the next edge, inside or outside the mode. Entry and resume in the same cycle take precedence over them.
- R10: The grant priority is: unblocked non-maskable first, then maskable (only when interrupt-enable is 1), then software. At most one grant is high in any cycle.
- R11: A non-maskable grant clears the latch and re-blocks until the next IRET or resume. An edge in the same cycle as the grant is latched for later.
- R12: Resume restores the three flags to their values at the accepted entry. An entry pulse inside the mode and a resume pulse outside it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_enter_i | input | 1 | Pulse: core enters the privileged mode |
| mode_exit_i | input | 1 | Pulse: resume instruction executed |
| iret_i | input | 1 | Pulse: IRET executed |
| sti_i | input | 1 | Pulse: STI executed |
| tf_set_i | input | 1 | Pulse: software sets the trap flag |
| dbg_arm_i | input | 1 | Pulse: software arms debug traps |
| boundary_i | input | 1 | Instruction boundary in this cycle |
| intr_req_i | input | 1 | Maskable interrupt request (level) |
| nmi_edge_i | input | 1 | Non-maskable request edge (one cycle) |
| swi_req_i | input | 1 | Software interrupt request |
| in_mode_o | output | 1 | Core is inside the privileged mode |
| if_o | output | 1 | Interrupt-enable flag |
| tf_o | output | 1 | Trap (single-step) flag |
| dbg_en_o | output | 1 | Debug-trap enable flag |
| take_nmi_o | output | 1 | Grant strobe: non-maskable |
| take_intr_o | output | 1 | Grant strobe: maskable |
| take_swi_o | output | 1 | Grant strobe: software interrupt |

## Verification
Directed sequences cover several cases. A request given outside the mode shows that the non-maskable path starts unblocked. Repeated edges inside the mode tell a one-deep latch apart from a counter or from a lost request. Release by IRET is tried separately from release by resume, with all three request kinds present at the first boundary after resume, which exposes a wrong priority order. An edge that lands in the same cycle as a grant separates "latched" from "dropped". Entry and resume pulses given in the wrong mode show whether the entry snapshot is overwritten. A long run of random pulses, compared cycle by cycle against a behavioural model, catches interactions between same-cycle entry, resume, IRET and grant that the directed cases leave out.

// File: rtl/irqg_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the privileged-mode interrupt gating controller.
// Assumes one flag register per bit and a fixed grant ordering by index.
package irqg_pkg;
    // Flag vector layout
    localparam int FLAG_W   = 3;
    localparam int FLAG_IF  = 0;
    localparam int FLAG_TF  = 1;
    localparam int FLAG_DBG = 2;

    // Grant vector layout, index 0 is highest priority
    localparam int SRC_W    = 3;
    localparam int SRC_NMI  = 0;
    localparam int SRC_INTR = 1;
    localparam int SRC_SWI  = 2;

    typedef logic [FLAG_W-1:0] flag_vec_t;
    typedef logic [SRC_W-1:0]  src_vec_t;
endpackage

// File: rtl/irqg_flag_unit.sv
`timescale 1ns/1ps
// Module: irqg_flag_unit
// Tracks whether the core is inside the privileged mode and keeps the
// per-source enable flags. Entry snapshots and clears every flag; resume
// restores the snapshot; otherwise a set pulse raises its flag.
// Assumes entry and resume are single-cycle pulses; a pulse in the wrong
// mode is ignored so that the snapshot is never overwritten.
module irqg_flag_unit
    import irqg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enter_i,
    input  logic      exit_i,
    input  flag_vec_t set_i,
    output logic      in_mode_o,
    output logic      enter_act_o,
    output logic      exit_act_o,
    output flag_vec_t flags_o
);
    logic      mode_q;
    flag_vec_t flag_q;
    flag_vec_t snap_q;

    // Qualify the pulses with the current mode
    assign enter_act_o = enter_i & ~mode_q;
    assign exit_act_o  = exit_i & mode_q;

    // Mode tracker: set on accepted entry, cleared on accepted resume
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (enter_act_o)
            mode_q <= 1'b1;
        else if (exit_act_o)
            mode_q <= 1'b0;
    end

    genvar g;
    generate
        for (g = 0; g < FLAG_W; g++) begin : g_flag
            // One flag with its entry snapshot: clear-and-save, restore, or set
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_q[g] <= 1'b0;
                    snap_q[g] <= 1'b0;
                end else if (enter_act_o) begin
                    snap_q[g] <= flag_q[g];
                    flag_q[g] <= 1'b0;
                end else if (exit_act_o) begin
                    flag_q[g] <= snap_q[g];
                end else if (set_i[g]) begin
                    flag_q[g] <= 1'b1;
                end
            end
        end
    endgenerate

    assign in_mode_o = mode_q;
    assign flags_o   = flag_q;

    // R2: an accepted entry leaves interrupts disabled
    assert_entry_clears_if_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enter_act_o |=> !flags_o[FLAG_IF]);
    // R3: an accepted entry leaves trap and debug disabled
    assert_entry_clears_traps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enter_act_o |=> (!flags_o[FLAG_TF] && !flags_o[FLAG_DBG]));
    // R12: resume puts back the values saved at entry
    assert_exit_restores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exit_act_o |=> (flags_o == $past(snap_q)));
    // R12: an entry pulse inside the mode keeps the flags
    assert_reentry_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && in_mode_o && !exit_i && set_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/irqg_nmi_unit.sv
`timescale 1ns/1ps
// Module: irqg_nmi_unit
// Holds the non-maskable block and a one-deep request latch. Entry and a
// grant raise the block; IRET or resume lowers it. An edge always sets the
// latch, a grant clears it, and an edge in the grant cycle survives.
// Assumes nmi_edge_i is already a single-cycle edge indication.
module irqg_nmi_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_act_i,
    input  logic exit_act_i,
    input  logic iret_i,
    input  logic nmi_edge_i,
    input  logic take_i,
    output logic blocked_o,
    output logic pending_o
);
    logic blocked_q;
    logic pending_q;

    // Block state: raise on entry or grant, lower on IRET or resume
    always_ff @(posedge clk) begin
        if (!rst_n)
            blocked_q <= 1'b0;
        else if (enter_act_i || take_i)
            blocked_q <= 1'b1;
        else if (iret_i || exit_act_i)
            blocked_q <= 1'b0;
    end

    // One-deep latch: set by an edge, cleared by a grant
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else
            pending_q <= (pending_q & ~take_i) | nmi_edge_i;
    end

    assign blocked_o = blocked_q;
    assign pending_o = pending_q;

    // R4: entry always leaves the request blocked
    assert_entry_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enter_act_i |=> blocked_o);
    // R11: a grant re-blocks
    assert_take_reblocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> blocked_o);
    // R5: a grant with no fresh edge empties the latch
    assert_single_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !nmi_edge_i) |=> !pending_o);
    // R6: IRET lifts the block when nothing re-raises it
    assert_iret_unblocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iret_i && !take_i && !enter_act_i) |=> !blocked_o);
    // R7: resume lifts the block when nothing re-raises it
    assert_exit_unblocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_act_i && !take_i) |=> !blocked_o);
endmodule

// File: rtl/irqg_arbiter.sv
`timescale 1ns/1ps
// Module: irqg_arbiter
// Fixed-priority one-hot grant, index 0 highest. Purely combinational;
// the clock is only used by the checks.
// Assumes requests are already qualified by boundary and enables.
module irqg_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    // Walk from highest priority down, granting the first request seen
    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

    // R10: never more than one grant
    assert_onehot_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    // R10: a grant only for a live request, and some grant when any request
    assert_grant_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o & ~req_i) == '0) && ((req_i != '0) == (grant_o != '0)));
endmodule

// File: rtl/irq_gate_ctrl.sv
`timescale 1ns/1ps
// Module: irq_gate_ctrl (top)
// Gates interrupt and trap sources while a core runs in a privileged
// management mode: clears flags on entry, blocks and latches the
// non-maskable request, restores flags on resume and grants one source
// per instruction boundary in the order non-maskable, maskable, software.
// Assumes all control inputs are single-cycle pulses, synchronous to clk.
module irq_gate_ctrl
    import irqg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_enter_i,
    input  logic mode_exit_i,
    input  logic iret_i,
    input  logic sti_i,
    input  logic tf_set_i,
    input  logic dbg_arm_i,
    input  logic boundary_i,
    input  logic intr_req_i,
    input  logic nmi_edge_i,
    input  logic swi_req_i,
    output logic in_mode_o,
    output logic if_o,
    output logic tf_o,
    output logic dbg_en_o,
    output logic take_nmi_o,
    output logic take_intr_o,
    output logic take_swi_o
);
    flag_vec_t flag_set;
    flag_vec_t flags;
    src_vec_t  req;
    src_vec_t  grant;
    logic      enter_act;
    logic      exit_act;
    logic      nmi_blocked;
    logic      nmi_pending;

    // Map the software set pulses onto the flag vector
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_IF]  = sti_i;
        flag_set[FLAG_TF]  = tf_set_i;
        flag_set[FLAG_DBG] = dbg_arm_i;
    end

    irqg_flag_unit u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_i     (mode_enter_i),
        .exit_i      (mode_exit_i),
        .set_i       (flag_set),
        .in_mode_o   (in_mode_o),
        .enter_act_o (enter_act),
        .exit_act_o  (exit_act),
        .flags_o     (flags)
    );

    irqg_nmi_unit u_nmi (
        .clk         (clk),
        .rst_n       (rst_n),
        .enter_act_i (enter_act),
        .exit_act_i  (exit_act),
        .iret_i      (iret_i),
        .nmi_edge_i  (nmi_edge_i),
        .take_i      (grant[SRC_NMI]),
        .blocked_o   (nmi_blocked),
        .pending_o   (nmi_pending)
    );

    // Qualify each source by boundary and its own enable
    always_comb begin
        req           = '0;
        req[SRC_NMI]  = boundary_i & nmi_pending & ~nmi_blocked;
        req[SRC_INTR] = boundary_i & intr_req_i & flags[FLAG_IF];
        req[SRC_SWI]  = boundary_i & swi_req_i;
    end

    irqg_arbiter #(.N(SRC_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .grant_o (grant)
    );

    assign if_o        = flags[FLAG_IF];
    assign tf_o        = flags[FLAG_TF];
    assign dbg_en_o    = flags[FLAG_DBG];
    assign take_nmi_o  = grant[SRC_NMI];
    assign take_intr_o = grant[SRC_INTR];
    assign take_swi_o  = grant[SRC_SWI];

    // R4: no non-maskable grant while blocked
    assert_nmi_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_blocked |-> !take_nmi_o);
    // R2: maskable grant only with interrupts enabled
    assert_intr_needs_if_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_intr_o |-> if_o);
    // R8: a software request is never held back by the mode
    assert_swi_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && swi_req_i && !take_nmi_o && !take_intr_o) |-> take_swi_o);
    // R10: grants appear only at boundaries
    assert_grant_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi_o || take_intr_o || take_swi_o) |-> boundary_i);
endmodule

// File: tb/tb_irq_gate_ctrl.sv
`timescale 1ns/1ps
// Bench: directed sequences plus a random run, with a behavioural model
// compared on every clock.
module tb_irq_gate_ctrl;
    localparam logic [9:0] S_ENT = 10'd1;
    localparam logic [9:0] S_EXT = 10'd2;
    localparam logic [9:0] S_IRT = 10'd4;
    localparam logic [9:0] S_STI = 10'd8;
    localparam logic [9:0] S_TFS = 10'd16;
    localparam logic [9:0] S_DBG = 10'd32;
    localparam logic [9:0] S_BND = 10'd64;
    localparam logic [9:0] S_INT = 10'd128;
    localparam logic [9:0] S_NMI = 10'd256;
    localparam logic [9:0] S_SWI = 10'd512;

    logic clk = 1'b0;
    logic rst_n;
    logic ent, ext, irt, sti, tfs, dba, bnd, intr, nmi, swi;
    logic in_mode, if_f, tf_f, dbg_f, t_nmi, t_intr, t_swi;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    int m_in, m_if, m_tf, m_dbg, m_blk, m_pend, s_if, s_tf, s_dbg;
    // grants captured in the last step
    int g_nmi, g_intr, g_swi;

    always #2 clk = ~clk;

    irq_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .mode_enter_i(ent), .mode_exit_i(ext), .iret_i(irt),
        .sti_i(sti), .tf_set_i(tfs), .dbg_arm_i(dba),
        .boundary_i(bnd), .intr_req_i(intr), .nmi_edge_i(nmi), .swi_req_i(swi),
        .in_mode_o(in_mode), .if_o(if_f), .tf_o(tf_f), .dbg_en_o(dbg_f),
        .take_nmi_o(t_nmi), .take_intr_o(t_intr), .take_swi_o(t_swi)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive after negedge, compare before posedge, advance model
    task automatic step(input logic [9:0] s);
        int en_n, ti, ts, old_in;
        @(negedge clk);
        {swi, nmi, intr, bnd, dba, tfs, sti, irt, ext, ent} = s;
        #1;
        en_n = (bnd && m_pend && !m_blk) ? 1 : 0;
        ti   = (bnd && intr && m_if && !en_n) ? 1 : 0;
        ts   = (bnd && swi && !en_n && !ti) ? 1 : 0;
        chk("R12", "in_mode", int'(in_mode), m_in);
        chk("R2",  "if",      int'(if_f),    m_if);
        chk("R3",  "tf",      int'(tf_f),    m_tf);
        chk("R3",  "dbg",     int'(dbg_f),   m_dbg);
        chk("R4",  "take_nmi",  int'(t_nmi),  en_n);
        chk("R10", "take_intr", int'(t_intr), ti);
        chk("R8",  "take_swi",  int'(t_swi),  ts);
        g_nmi = int'(t_nmi); g_intr = int'(t_intr); g_swi = int'(t_swi);
        @(posedge clk);
        old_in = m_in;
        if (ent && !old_in) begin
            m_in = 1; s_if = m_if; s_tf = m_tf; s_dbg = m_dbg;
            m_if = 0; m_tf = 0; m_dbg = 0; m_blk = 1;
        end else begin
            if (ext && old_in) begin
                m_in = 0; m_if = s_if; m_tf = s_tf; m_dbg = s_dbg;
            end else begin
                if (sti) m_if = 1;
                if (tfs) m_tf = 1;
                if (dba) m_dbg = 1;
            end
            if (en_n) m_blk = 1;
            else if (irt || (ext && old_in)) m_blk = 0;
        end
        m_pend = ((m_pend && !en_n) || nmi) ? 1 : 0;
        #1;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        {swi, nmi, intr, bnd, dba, tfs, sti, irt, ext, ent} = '0;
        rst_n = 1'b0;
        m_in = 0; m_if = 0; m_tf = 0; m_dbg = 0; m_blk = 0; m_pend = 0;
        s_if = 0; s_tf = 0; s_dbg = 0;
        g_nmi = 0; g_intr = 0; g_swi = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "in_mode", int'(in_mode), 0);
        chk("R1", "if/tf/dbg", int'({if_f, tf_f, dbg_f}), 0);
        step(S_NMI); step(S_BND);
        chk("R1", "nmi granted from reset", g_nmi, 1);
        // R11: grant re-blocks until IRET
        step(S_NMI); step(S_BND);
        chk("R11", "nmi held after grant", g_nmi, 0);
        step(S_IRT); step(S_BND);
        chk("R11", "nmi after iret", g_nmi, 1);
        step(S_IRT);
        // R9: set pulses outside the mode
        step(S_STI | S_TFS | S_DBG);
        chk("R9", "flags set", int'({if_f, tf_f, dbg_f}), 7);
        step(S_BND | S_INT | S_SWI);
        chk("R10", "intr over swi", g_intr * 2 + g_swi, 2);
        // R2 R3: entry
        step(S_ENT);
        chk("R2", "if after entry", int'(if_f), 0);
        chk("R3", "tf/dbg after entry", int'({tf_f, dbg_f}), 0);
        step(S_BND | S_INT);
        chk("R2", "intr ignored in mode", g_intr, 0);
        step(S_BND | S_INT | S_SWI);
        chk("R8", "swi in mode", g_swi, 1);
        // R4 R5 R6: block, single latch, IRET release
        step(S_NMI); step(S_NMI); step(S_BND);
        chk("R4", "nmi blocked", g_nmi, 0);
        step(S_IRT); step(S_BND);
        chk("R6", "nmi after iret", g_nmi, 1);
        step(S_IRT); step(S_BND);
        chk("R5", "only one latched", g_nmi, 0);
        // R9 R12: STI inside, re-entry ignored, restore on resume
        step(S_STI);
        chk("R9", "sti in mode", int'({if_f, tf_f}), 2);
        step(S_ENT);
        chk("R12", "reentry keeps flags", int'(if_f), 1);
        step(S_EXT);
        chk("R12", "restored flags", int'({in_mode, if_f, tf_f, dbg_f}), 7);
        step(S_EXT | S_STI);
        chk("R12", "exit outside ignored", int'({in_mode, if_f, tf_f, dbg_f}), 7);
        // R7: pending taken first after resume
        step(S_ENT); step(S_NMI); step(S_EXT);
        step(S_BND | S_INT | S_SWI);
        chk("R7", "nmi first after resume", g_nmi * 4 + g_intr * 2 + g_swi, 4);
        step(S_IRT);
        // R11: edge in the grant cycle is kept
        step(S_NMI); step(S_BND | S_NMI);
        chk("R11", "grant with fresh edge", g_nmi, 1);
        step(S_BND);
        chk("R11", "fresh edge held", g_nmi, 0);
        step(S_IRT); step(S_BND);
        chk("R11", "fresh edge granted", g_nmi, 1);
        step(S_IRT);
        // Random run against the model
        for (int k = 0; k < 600; k++) begin
            logic [9:0] s;
            s = '0;
            s[0] = ($urandom % 12) == 0;
            s[1] = ($urandom % 12) == 0;
            for (int b = 2; b < 10; b++) s[b] = ($urandom % 4) == 0;
            step(s);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule